// File: doc/BRIEF.md
# Loss-Free Retirement Trace Capture

This block sits between a processor core and a bounded trace store. For each retirement the core reports, it bundles the program counter, the 32-bit instruction word and a bitmap of performance-event flags into one trace entry. It pushes that entry into a small FIFO. Each event flag is one bit that is high in the cycle its event is active. The events include traps, branches, jumps, loads, stores, interrupts, cache loads and misses, and bus handshake beats on both the master and slave sides. The bitmap is 39 bits wide by default. The block does not choose which events feed it.

Trace entries must never be dropped. When the FIFO nears its capacity, the block raises a halt request. The integration ORs this request into the core's own halting condition, so the core stops retiring until a consumer drains entries through the valid/ready pop port. The halt request comes from a register. For that reason the FIFO keeps one slot spare, and occupancy never rises above depth minus one. The pop port follows the usual stream rules. An entry is presented whenever the FIFO is non-empty and leaves on a cycle where valid and ready are both high. While valid is high and ready is low, the presented entry holds. The consumer may hold ready low for as long as it likes; the only effect is that the core stays halted.

Capture is gated by a registered reset-complete flag. The flag is cleared by reset and set once the core reports that its reset sequence has finished. This stops spurious retirements seen during the reset sequence from entering the trace.

Top module: `trace_capture`

## Requirements
- R1: During and directly after reset, `armed`, `halt_req` and `tr_valid` are all low.
- R2: `armed` goes high on the clock edge at which `core_rst_done` is sampled high. It then stays high until the next reset.
- R3: While `armed` is low, a high `retire_valid` stores nothing, so `tr_valid` stays low.
- R4: A retirement is stored when `armed` and `retire_valid` are high and `halt_req` is low. The entry's `tr_pc`, `tr_instr` and `tr_events` equal the `pc`, `instr` and `events` inputs of that cycle.
- R5: `halt_req` is a register. It is high in exactly those cycles where FIFO occupancy is at least DEPTH-1, where occupancy counts the push and pop of the previous edge.
- R6: While `halt_req` is high, a high `retire_valid` stores nothing.
- R7: Occupancy never exceeds DEPTH-1. Filling with no pops stores exactly DEPTH-1 entries, and all of them can be drained.
- R8: `tr_valid` is high exactly when the FIFO holds an entry. An entry is removed only on a cycle where `tr_valid` and `tr_ready` are both high. While `tr_valid` is high and `tr_ready` is low, the outputs hold.
- R9: Entries leave in the same order in which they were stored.
- R10: A push and a pop on the same edge both take effect, so occupancy is unchanged and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_rst_done | input | 1 | Core reports that its reset sequence is finished |
| retire_valid | input | 1 | An instruction retires this cycle |
| pc | input | PC_W | Program counter of the retiring instruction |
| instr | input | INSTR_W | Instruction word |
| events | input | EVT_W | Event flags active this cycle |
| armed | output | 1 | Registered reset-complete flag |
| halt_req | output | 1 | Halt request, to be ORed into the core halt |
| tr_valid | output | 1 | Trace entry available |
| tr_ready | input | 1 | Consumer accepts the entry |
| tr_pc | output | PC_W | Entry program counter |
| tr_instr | output | INSTR_W | Entry instruction word |
| tr_events | output | EVT_W | Entry event bitmap |

## Verification
The assertions check five properties on every cycle. The first is that `armed` is sticky and follows `core_rst_done`. The second is that no entry appears before arming. The third is that the halt request tracks the occupancy threshold and that occupancy never grows while halted. The fourth is that the spare slot is never used. The fifth is that the presented entry is stable under back-pressure. Other properties can only be shown by the bench scenarios. Those are data integrity, push-order delivery, the exact count of DEPTH-1 stored entries on a blocked fill, and correct behaviour when push and pop share an edge. The bench drives these scenarios across a sweep of retire and ready densities.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_INSTR_W = 32;
  localparam int unsigned DEF_EVT_W   = 39;
  localparam int unsigned DEF_DEPTH   = 16;
  localparam int unsigned DEF_SLACK   = 1;

  // Occupancy at which the registered halt must be raised.
  function automatic int unsigned halt_level(input int unsigned depth,
                                             input int unsigned slack);
    return depth - slack;
  endfunction
endpackage

// File: rtl/trace_arm_gate.sv
module trace_arm_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst_done,
  output logic armed
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             armed_q <= 1'b0;
    else if (core_rst_done) armed_q <= 1'b1;
  end

  assign armed = armed_q;
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_next
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;
  assign occ_next  = cnt + CW'(do_push) - CW'(do_pop);
  assign occ       = cnt;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt <= occ_next;
    end
  end
endmodule

// File: rtl/trace_halt.sv
module trace_halt #(
  parameter int unsigned CW    = 5,
  parameter int unsigned LEVEL = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ_next,
  output logic          halt_req
);
  logic halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= (occ_next >= CW'(LEVEL));
  end

  assign halt_req = halt_q;
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_cap_pkg::*;
#(
  parameter int unsigned PC_W    = DEF_PC_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned EVT_W   = DEF_EVT_W,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  parameter int unsigned SLACK   = DEF_SLACK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_rst_done,
  input  logic               retire_valid,
  input  logic [PC_W-1:0]    pc,
  input  logic [INSTR_W-1:0] instr,
  input  logic [EVT_W-1:0]   events,
  output logic               armed,
  output logic               halt_req,
  output logic               tr_valid,
  input  logic               tr_ready,
  output logic [PC_W-1:0]    tr_pc,
  output logic [INSTR_W-1:0] tr_instr,
  output logic [EVT_W-1:0]   tr_events
);
  localparam int unsigned W     = PC_W + INSTR_W + EVT_W;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned LEVEL = halt_level(DEPTH, SLACK);

  logic          push;
  logic          full;
  logic [W-1:0]  din, dout;
  logic [CW-1:0] occ, occ_next;

  trace_arm_gate u_gate (
    .clk(clk), .rst_n(rst_n), .core_rst_done(core_rst_done), .armed(armed)
  );

  assign push = armed && retire_valid && !halt_req && !full;
  assign din  = {pc, instr, events};

  trace_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(din), .full(full),
    .out_valid(tr_valid), .out_ready(tr_ready), .dout(dout),
    .occ(occ), .occ_next(occ_next)
  );

  trace_halt #(.CW(CW), .LEVEL(LEVEL)) u_halt (
    .clk(clk), .rst_n(rst_n), .occ_next(occ_next), .halt_req(halt_req)
  );

  assign tr_pc     = dout[W-1 -: PC_W];
  assign tr_instr  = dout[EVT_W +: INSTR_W];
  assign tr_events = dout[EVT_W-1:0];
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned EVT_W   = 39,
  parameter int unsigned CW      = 5,
  parameter int unsigned LEVEL   = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_rst_done,
  input logic               armed,
  input logic               halt_req,
  input logic               tr_valid,
  input logic               tr_ready,
  input logic [PC_W-1:0]    tr_pc,
  input logic [INSTR_W-1:0] tr_instr,
  input logic [EVT_W-1:0]   tr_events,
  input logic [CW-1:0]      occ
);
  AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_done |=> armed); // R2
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R2
  AST_NO_ENTRY_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !tr_valid); // R3
  AST_HALT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req == (occ >= CW'(LEVEL))); // R5
  AST_HALT_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> occ <= $past(occ)); // R6
  AST_SPARE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(LEVEL)); // R7
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid && !tr_ready |=> tr_valid && $stable(tr_pc) && $stable(tr_instr)
                              && $stable(tr_events)); // R8
endmodule

bind trace_capture trace_capture_chk #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .EVT_W(EVT_W), .CW(CW), .LEVEL(LEVEL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_done(core_rst_done), .armed(armed),
  .halt_req(halt_req), .tr_valid(tr_valid), .tr_ready(tr_ready),
  .tr_pc(tr_pc), .tr_instr(tr_instr), .tr_events(tr_events), .occ(occ)
);

// File: tb/trace_capture_tb.sv
module trace_capture_tb;
  localparam int PC_W = 32, INSTR_W = 32, EVT_W = 39, DEPTH = 16, LEVEL = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_rst_done = 1'b0, retire_valid = 1'b0, tr_ready = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic [INSTR_W-1:0] instr = '0;
  logic [EVT_W-1:0] events = '0;
  logic armed, halt_req, tr_valid;
  logic [PC_W-1:0] tr_pc;
  logic [INSTR_W-1:0] tr_instr;
  logic [EVT_W-1:0] tr_events;

  trace_capture u_dut (
    .clk(clk), .rst_n(rst_n), .core_rst_done(core_rst_done),
    .retire_valid(retire_valid), .pc(pc), .instr(instr), .events(events),
    .armed(armed), .halt_req(halt_req), .tr_valid(tr_valid),
    .tr_ready(tr_ready), .tr_pc(tr_pc), .tr_instr(tr_instr),
    .tr_events(tr_events)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, seq = 0, m_cnt = 0, q_rd = 0, q_wr = 0, dut_pops = 0;
  bit m_halt = 0, m_armed = 0, last_both = 0, done = 0;
  logic [PC_W-1:0] q_pc [DEPTH];
  logic [INSTR_W-1:0] q_in [DEPTH];
  logic [EVT_W-1:0] q_ev [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R2 armed", 64'(armed), 64'(m_armed));
    chk("R5 halt_req", 64'(halt_req), 64'(m_halt));
    chk("R3 R6 R8 tr_valid", 64'(tr_valid), 64'(m_cnt > 0));
    if (m_cnt > 0) begin
      chk(last_both ? "R10 tr_pc" : "R4 R9 tr_pc", 64'(tr_pc), 64'(q_pc[q_rd]));
      chk(last_both ? "R10 tr_instr" : "R4 R9 tr_instr", 64'(tr_instr), 64'(q_in[q_rd]));
      chk(last_both ? "R10 tr_events" : "R4 R9 tr_events", 64'(tr_events), 64'(q_ev[q_rd]));
    end
  endtask

  task automatic step(input bit rv, input bit rdy, input bit rd);
    bit push, pop;
    @(negedge clk);
    check_outputs();
    retire_valid = rv; tr_ready = rdy; core_rst_done = rd;
    pc = 32'h1000 + 32'(seq) * 4;
    instr = 32'(seq) * 32'h9E3779B1;
    events = {7'(seq), 32'(seq) * 32'h01000193};
    if (tr_valid && rdy) dut_pops++;
    push = m_armed && rv && !m_halt;
    pop = (m_cnt > 0) && rdy;
    if (pop) q_rd = (q_rd + 1) % DEPTH;
    if (push) begin
      q_pc[q_wr] = pc; q_in[q_wr] = instr; q_ev[q_wr] = events;
      q_wr = (q_wr + 1) % DEPTH;
    end
    m_cnt = m_cnt + int'(push) - int'(pop);
    m_halt = (m_cnt >= LEVEL);
    m_armed = m_armed || rd;
    last_both = push && pop;
    seq++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; retire_valid = 0; tr_ready = 0; core_rst_done = 0;
    repeat (3) @(negedge clk);
    chk("R1 armed in reset", 64'(armed), 64'd0);
    chk("R1 halt_req in reset", 64'(halt_req), 64'd0);
    chk("R1 tr_valid in reset", 64'(tr_valid), 64'd0);
    m_cnt = 0; q_rd = 0; q_wr = 0; m_halt = 0; m_armed = 0; last_both = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R3: retirements before arming are dropped
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    step(1, 0, 1);                                   // R2 arm
    // R5 R6 R7: blocked fill
    for (int i = 0; i < 25; i++) step(1, 0, 0);
    dut_pops = 0;
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    chk("R7 entries stored on blocked fill", 64'(dut_pops), 64'(LEVEL));
    // density sweep of retire and ready
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 60; c++) begin
        bit rv, rdy;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rv  = (p[1:0] == 2'd3) ? 1'b1 : (lfsr[1:0] <= p[1:0]);
        rdy = (p[3:2] == 2'd3) ? 1'b1 : (lfsr[5:4] <= p[3:2]);
        step(rv, rdy, 0);
      end
    end
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    // second reset: disarmed again, retirements ignored (R1 R3)
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    step(0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule